// File: doc/BRIEF.md
# Class-Latency Issue Interlock

This block sits at the issue point of a single-issue, in-order pipeline. Each cycle it looks at the decoded instruction presented to it and decides whether that instruction issues or is held for one more cycle. The decision comes from a record of results that are still in flight. Each of the 32 integer and 32 floating-point registers has a small down-counter and the class of the instruction that last wrote it.

The number of bubbles between a producer and a consumer is not a fixed penalty. It is read from a table indexed by the producer's class and by the way the consumer uses the operand. The table is asymmetric. The data operand of a store has its own rules, separate from the operands of arithmetic. Integer-to-integer use has no wait. An integer result tested by a branch waits one cycle, and a taken-or-not branch is followed by one bubble cycle for its delay slot.

The block also keeps a running count of the cycles in which a valid instruction was held. With the default settings, a five-instruction array-update loop takes 10 cycles per iteration, and 5 of those cycles are bubbles. The loop is a load, an FP add, a store, a pointer decrement and a branch.

Top module: `ilk_issue_interlock`

## Requirements
- R1: After reset, no result is pending and `bubble_cnt` is 0. `issue` and `stall` are never high together, and `stall` is high exactly when `in_valid` is high and `issue` is low.
- R2: An FP ALU result (class 1) read as either operand of a later FP ALU instruction needs 3 idle cycles between the two. Each independent instruction placed between them removes one required bubble.
- R3: An FP ALU result read as the store data (`in_src2` of class 3) needs 2 idle cycles between the two.
- R4: An FP load result (class 2) read by an FP ALU instruction needs 1 idle cycle between the two.
- R5: These uses need no idle cycles: an FP load result used as store data, an integer result (class 0) read by another integer instruction, and an integer result read as the address base (`in_src1`) of a load or store.
- R6: An integer result tested by a branch (class 4, register in `in_src1`) needs 1 idle cycle between the two.
- R7: In the cycle after a branch issues, nothing issues. A valid instruction presented in that cycle is held and counted as a bubble.
- R8: An integer instruction with destination 0 creates no pending result, so a reader of integer register 0 never waits.
- R9: A cycle with `in_valid` low gives no issue and no stall. It records nothing, and pending counts still age by one.
- R10: `bubble_cnt` increases by one in each cycle with `stall` high. The loop load, FP add, store, decrement, branch takes 10 cycles from one load issue to the next, and 5 of those cycles are bubbles.
- R11: Only the operands a class actually reads are checked. Integer and FP ALU instructions read `in_src1` and `in_src2`. A load reads the integer base in `in_src1`. A store reads the integer base in `in_src1` and the FP data in `in_src2`. A branch reads the integer register in `in_src1`. Only integer (with destination other than 0), FP ALU and load instructions write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_class | input | 3 | 0 integer, 1 FP ALU, 2 FP load, 3 FP store, 4 branch |
| in_dst | input | 5 | Destination register number |
| in_src1 | input | 5 | First source register number |
| in_src2 | input | 5 | Second source register number |
| issue | output | 1 | The presented instruction issues this cycle |
| stall | output | 1 | The presented instruction is held this cycle |
| bubble_cnt | output | BCNT_W | Number of held cycles since reset |

## Verification
The stimuli are chosen so that each class pair is tried both back to back and with independent instructions placed between producer and consumer. A wrong table entry and a wrong aging rule therefore give different issue cycles. Some streams carry the dependent register number in an operand field that the class does not read, or write it through integer register 0. Any stall in these streams shows that an unread field or a zero destination has been treated as live. Invalid cycles are placed inside dependence windows, which separates "time passes" from "an instruction was recorded". The full loop then checks the 10-cycle, 5-bubble total and the delay-slot bubble together.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int REG_W  = 5;
    localparam int NREG   = 2 * (1 << REG_W);
    localparam int IDX_W  = REG_W + 1;
    localparam int LAT_W  = 2;
    localparam int CLS_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        CL_INT   = 3'd0,
        CL_FPALU = 3'd1,
        CL_FPLD  = 3'd2,
        CL_FPST  = 3'd3,
        CL_BR    = 3'd4
    } iclass_e;

    // How a consumer uses an operand
    typedef enum logic [1:0] {
        US_INTOP  = 2'd0,
        US_BRTEST = 2'd1,
        US_FPOP   = 2'd2,
        US_STDATA = 2'd3
    } use_e;

    typedef struct packed {
        logic             used;
        logic             fp;
        logic [REG_W-1:0] num;
        use_e             kind;
    } src_t;

    // Longest wait any consumer may need after this producer
    function automatic logic [LAT_W-1:0] lat_max(input iclass_e p);
        case (p)
            CL_INT:   lat_max = 2'd1;
            CL_FPALU: lat_max = 2'd3;
            CL_FPLD:  lat_max = 2'd1;
            default:  lat_max = 2'd0;
        endcase
    endfunction

    // Idle cycles a given use needs after a given producer
    function automatic logic [LAT_W-1:0] lat_need(input iclass_e p, input use_e u);
        lat_need = 2'd0;
        case (p)
            CL_INT:   if (u == US_BRTEST) lat_need = 2'd1;
            CL_FPALU: begin
                if (u == US_FPOP)   lat_need = 2'd3;
                if (u == US_STDATA) lat_need = 2'd2;
            end
            CL_FPLD:  if (u == US_FPOP) lat_need = 2'd1;
            default:  lat_need = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ilk_decode.sv
module ilk_decode
    import ilk_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src1,
    input  logic [REG_W-1:0] src2,
    output src_t             src_a,
    output src_t             src_b,
    output logic             dst_we,
    output logic             dst_fp
);

    always_comb begin
        src_a  = '{used: 1'b0, fp: 1'b0, num: src1, kind: US_INTOP};
        src_b  = '{used: 1'b0, fp: 1'b0, num: src2, kind: US_INTOP};
        dst_we = 1'b0;
        dst_fp = 1'b0;
        case (iclass_e'(cls))
            CL_INT: begin
                src_a.used = 1'b1;
                src_b.used = 1'b1;
                dst_we     = (dst != '0);
            end
            CL_FPALU: begin
                src_a = '{used: 1'b1, fp: 1'b1, num: src1, kind: US_FPOP};
                src_b = '{used: 1'b1, fp: 1'b1, num: src2, kind: US_FPOP};
                dst_we = 1'b1;
                dst_fp = 1'b1;
            end
            CL_FPLD: begin
                src_a.used = 1'b1;
                dst_we     = 1'b1;
                dst_fp     = 1'b1;
            end
            CL_FPST: begin
                src_a.used = 1'b1;
                src_b = '{used: 1'b1, fp: 1'b1, num: src2, kind: US_STDATA};
            end
            CL_BR: begin
                src_a = '{used: 1'b1, fp: 1'b0, num: src1, kind: US_BRTEST};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
    import ilk_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ld_en,
    input  logic [IDX_W-1:0]                 ld_idx,
    input  logic [CLS_W-1:0]                 ld_cls,
    output logic [NREG-1:0][LAT_W-1:0]       cnt_o,
    output logic [NREG-1:0][CLS_W-1:0]       cls_o
);

    typedef struct packed {
        logic [NREG-1:0][LAT_W-1:0] cnt;
        logic [NREG-1:0][CLS_W-1:0] cls;
    } sb_t;

    sb_t sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        for (int i = 0; i < NREG; i++) begin
            if (sb_q.cnt[i] != '0) sb_d.cnt[i] = sb_q.cnt[i] - 1'b1;
            if (ld_en && (ld_idx == IDX_W'(i))) begin
                sb_d.cnt[i] = lat_max(iclass_e'(ld_cls));
                sb_d.cls[i] = ld_cls;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign cnt_o = sb_q.cnt;
    assign cls_o = sb_q.cls;

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
    import ilk_pkg::*;
(
    input  logic [NREG-1:0][LAT_W-1:0] cnt_i,
    input  logic [NREG-1:0][CLS_W-1:0] cls_i,
    input  src_t                       src_i,
    output logic                       blocked_o
);

    logic [IDX_W-1:0] idx;
    iclass_e          prod;
    logic [LAT_W:0]   sum;

    always_comb begin
        idx       = {src_i.fp, src_i.num};
        prod      = iclass_e'(cls_i[idx]);
        sum       = {1'b0, cnt_i[idx]} + {1'b0, lat_need(prod, src_i.kind)};
        blocked_o = src_i.used && (src_i.fp || (src_i.num != '0))
                    && (sum > {1'b0, lat_max(prod)});
    end

endmodule

// File: rtl/ilk_issue_interlock.sv
module ilk_issue_interlock
    import ilk_pkg::*;
#(
    parameter int BCNT_W       = 16,
    parameter bit DELAY_BUBBLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_class,
    input  logic [4:0]        in_dst,
    input  logic [4:0]        in_src1,
    input  logic [4:0]        in_src2,
    output logic              issue,
    output logic              stall,
    output logic [BCNT_W-1:0] bubble_cnt
);

    localparam int NSRC = 2;

    typedef struct packed {
        logic              slot;
        logic [BCNT_W-1:0] bub;
    } st_t;

    st_t st_d, st_q;

    src_t                       srcs [NSRC];
    logic [NSRC-1:0]            blk;
    logic                       dst_we, dst_fp;
    logic [NREG-1:0][LAT_W-1:0] cnt;
    logic [NREG-1:0][CLS_W-1:0] pcls;
    logic                       br_issue;

    ilk_decode u_dec (
        .cls    (in_class),
        .dst    (in_dst),
        .src1   (in_src1),
        .src2   (in_src2),
        .src_a  (srcs[0]),
        .src_b  (srcs[1]),
        .dst_we (dst_we),
        .dst_fp (dst_fp)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_hz
        ilk_hazard u_hz (
            .cnt_i     (cnt),
            .cls_i     (pcls),
            .src_i     (srcs[g]),
            .blocked_o (blk[g])
        );
    end

    ilk_scoreboard u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (issue && dst_we),
        .ld_idx ({dst_fp, in_dst}),
        .ld_cls (in_class),
        .cnt_o  (cnt),
        .cls_o  (pcls)
    );

    if (DELAY_BUBBLE) begin : g_slot
        assign br_issue = issue && (iclass_e'(in_class) == CL_BR);
    end else begin : g_noslot
        assign br_issue = 1'b0;
    end

    always_comb begin
        issue    = in_valid && (blk == '0) && !st_q.slot;
        stall    = in_valid && !issue;
        st_d     = st_q;
        st_d.slot = br_issue;
        if (stall) st_d.bub = st_q.bub + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bubble_cnt = st_q.bub;

endmodule

// File: rtl/ilk_issue_interlock_chk.sv
module ilk_issue_interlock_chk #(
    parameter int BCNT_W       = 16,
    parameter bit DELAY_BUBBLE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_class,
    input logic [4:0]        in_dst,
    input logic [4:0]        in_src1,
    input logic [4:0]        in_src2,
    input logic              issue,
    input logic              stall,
    input logic [BCNT_W-1:0] bubble_cnt
);

    p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && stall));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!issue && !stall));

    p_fpalu_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_class == 3'd1) |=>
        !(issue && in_class == 3'd1 &&
          (in_src1 == $past(in_dst) || in_src2 == $past(in_dst))));

    p_stdata_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_class == 3'd1) |=>
        !(issue && in_class == 3'd3 && in_src2 == $past(in_dst)));

    p_brtest_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_class == 3'd0 && in_dst != 5'd0) |=>
        !(issue && in_class == 3'd4 && in_src1 == $past(in_dst)));

    p_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (DELAY_BUBBLE && issue && in_class == 3'd4) |=> !issue);

    p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> bubble_cnt == $past(bubble_cnt) + BCNT_W'($past(stall)));

endmodule

bind ilk_issue_interlock ilk_issue_interlock_chk #(
    .BCNT_W       (BCNT_W),
    .DELAY_BUBBLE (DELAY_BUBBLE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_class   (in_class),
    .in_dst     (in_dst),
    .in_src1    (in_src1),
    .in_src2    (in_src2),
    .issue      (issue),
    .stall      (stall),
    .bubble_cnt (bubble_cnt)
);

// File: tb/ilk_issue_interlock_bench.sv
`timescale 1ns/1ps
module ilk_issue_interlock_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_class = '0;
    logic [4:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic        issue, stall;
    logic [15:0] bubble_cnt;

    always #2 clk = ~clk;

    ilk_issue_interlock u_ilk_issue_interlock (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .issue(issue), .stall(stall), .bubble_cnt(bubble_cnt)
    );

    typedef struct { bit v; int cls; int dst; int s1; int s2; } ins_t;

    ins_t  prog[$];
    int    issued_at[$];
    int    n_cmp = 0, n_bad = 0;
    int    cyc = 0;
    int    last_stalls = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // reference: issue time stamps per register
    bit m_pend[64];
    int m_cls[64];
    int m_t[64];
    int m_bub = 0;
    int m_slot = -10;

    function automatic ins_t mk(int c, int d, int a, int b);
        ins_t x; x.v = 1; x.cls = c; x.dst = d; x.s1 = a; x.s2 = b; return x;
    endfunction

    function automatic ins_t idle();
        ins_t x; x.v = 0; x.cls = 0; x.dst = 0; x.s1 = 0; x.s2 = 0; return x;
    endfunction

    // kinds: 0 integer operand, 1 branch test, 2 FP operand, 3 store data
    function automatic int m_need(int p, int k);
        if (p == 0) return (k == 1) ? 1 : 0;
        if (p == 1) return (k == 2) ? 3 : ((k == 3) ? 2 : 0);
        if (p == 2) return (k == 2) ? 1 : 0;
        return 0;
    endfunction

    function automatic bit m_wait(bit fp, int num, int kind);
        int idx;
        if (!fp && num == 0) return 0;
        idx = (fp ? 32 : 0) + num;
        if (!m_pend[idx]) return 0;
        return (cyc - m_t[idx] - 1) < m_need(m_cls[idx], kind);
    endfunction

    function automatic bit m_blocked(ins_t x);
        case (x.cls)
            0: return m_wait(0, x.s1, 0) || m_wait(0, x.s2, 0);
            1: return m_wait(1, x.s1, 2) || m_wait(1, x.s2, 2);
            2: return m_wait(0, x.s1, 0);
            3: return m_wait(0, x.s1, 0) || m_wait(1, x.s2, 3);
            4: return m_wait(0, x.s1, 1);
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic step(ins_t x, output bit iss);
        bit e_iss, e_stall;
        @(negedge clk);
        in_valid = x.v; in_class = 3'(x.cls); in_dst = 5'(x.dst);
        in_src1 = 5'(x.s1); in_src2 = 5'(x.s2);
        #1;
        e_iss   = x.v && !m_blocked(x) && (m_slot != cyc);
        e_stall = x.v && !e_iss;
        check(cur_req, int'(issue), int'(e_iss), "issue");
        check(cur_req, int'(stall), int'(e_stall), "stall");
        check("R10", int'(bubble_cnt), m_bub, "bubble_cnt");
        if (e_stall) m_bub++;
        if (e_iss) begin
            if ((x.cls == 0 && x.dst != 0) || x.cls == 1 || x.cls == 2) begin
                int idx;
                idx = (x.cls == 0 ? 0 : 32) + x.dst;
                m_pend[idx] = 1; m_cls[idx] = x.cls; m_t[idx] = cyc;
            end
            if (x.cls == 4) m_slot = cyc + 1;
        end
        iss = e_iss;
        cyc++;
    endtask

    task automatic run_prog();
        bit iss;
        int b0;
        b0 = m_bub;
        issued_at.delete();
        while (prog.size() > 0) begin
            step(prog[0], iss);
            if (!prog[0].v) begin
                issued_at.push_back(-1); void'(prog.pop_front());
            end else if (iss) begin
                issued_at.push_back(cyc - 1); void'(prog.pop_front());
            end
        end
        for (int i = 0; i < 4; i++) step(idle(), iss);
        last_stalls = m_bub - b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_pend[i] = 0; m_cls[i] = 0; m_t[i] = 0; end
        repeat (3) @(negedge clk);
        check("R1", int'(bubble_cnt), 0, "bubble_cnt in reset");
        check("R1", int'(issue), 0, "issue in reset");
        rst_n = 1'b1;

        // R1: idle after reset
        cur_req = "R1";
        prog.push_back(idle()); prog.push_back(idle());
        run_prog();
        check("R1", int'(bubble_cnt), 0, "bubble_cnt after idle");

        // R2: FP ALU to FP ALU back to back, then with one gap instruction
        cur_req = "R2";
        prog.push_back(mk(1, 4, 0, 2)); prog.push_back(mk(1, 6, 2, 4));
        run_prog();
        check("R2", last_stalls, 3, "stalls back to back");
        check("R2", issued_at[1] - issued_at[0], 4, "issue distance");
        prog.push_back(mk(1, 8, 0, 2)); prog.push_back(mk(0, 3, 3, 3));
        prog.push_back(mk(1, 10, 8, 2));
        run_prog();
        check("R2", last_stalls, 2, "stalls with one gap");

        // R3: FP ALU to store data
        cur_req = "R3";
        prog.push_back(mk(1, 4, 0, 2)); prog.push_back(mk(3, 0, 1, 4));
        run_prog();
        check("R3", last_stalls, 2, "stalls to store data");

        // R4: load to FP ALU
        cur_req = "R4";
        prog.push_back(mk(2, 0, 1, 0)); prog.push_back(mk(1, 4, 0, 2));
        run_prog();
        check("R4", last_stalls, 1, "stalls load to FP op");

        // R5: zero-wait pairs
        cur_req = "R5";
        prog.push_back(mk(2, 0, 1, 0)); prog.push_back(mk(3, 0, 1, 0));
        prog.push_back(mk(0, 3, 1, 1)); prog.push_back(mk(0, 5, 3, 3));
        prog.push_back(mk(0, 1, 1, 0)); prog.push_back(mk(2, 6, 1, 0));
        prog.push_back(mk(0, 2, 2, 0)); prog.push_back(mk(3, 0, 2, 6));
        run_prog();
        check("R5", last_stalls, 0, "stalls zero-wait pairs");

        // R6: integer result tested by branch (empty delay slot)
        cur_req = "R6";
        prog.push_back(mk(0, 1, 1, 0)); prog.push_back(mk(4, 0, 1, 0));
        run_prog();
        check("R6", last_stalls, 1, "stalls int to branch");

        // R7: delay slot bubble
        cur_req = "R7";
        prog.push_back(mk(4, 0, 9, 0)); prog.push_back(mk(0, 3, 4, 4));
        run_prog();
        check("R7", last_stalls, 1, "delay slot bubble");
        check("R7", issued_at[1] - issued_at[0], 2, "issue distance after branch");

        // R8: writes to integer register 0
        cur_req = "R8";
        prog.push_back(mk(0, 0, 1, 1)); prog.push_back(mk(4, 0, 0, 0));
        run_prog();
        check("R8", last_stalls, 0, "stalls on register 0");

        // R9: invalid cycles age counts but record nothing
        cur_req = "R9";
        prog.push_back(mk(1, 4, 0, 2)); prog.push_back(idle()); prog.push_back(idle());
        prog.push_back(mk(3, 0, 1, 4));
        run_prog();
        check("R9", last_stalls, 0, "stalls after two idle cycles");
        prog.push_back(idle()); prog.push_back(mk(1, 7, 0, 2));
        run_prog();
        prog.delete();
        begin
            ins_t ghost;
            ghost = mk(1, 12, 0, 2); ghost.v = 0;
            prog.push_back(ghost); prog.push_back(mk(3, 0, 1, 12));
        end
        run_prog();
        check("R9", last_stalls, 0, "invalid producer recorded nothing");

        // R11: unread operand fields are ignored
        cur_req = "R11";
        prog.push_back(mk(1, 4, 0, 2)); prog.push_back(mk(2, 8, 1, 4));
        prog.push_back(mk(4, 0, 3, 4)); prog.push_back(idle());
        prog.push_back(mk(3, 4, 1, 0));
        run_prog();
        check("R11", last_stalls, 0, "stalls on unread fields");

        // R10: array-update loop, two iterations
        cur_req = "R10";
        for (int it = 0; it < 2; it++) begin
            prog.push_back(mk(2, 0, 1, 0)); prog.push_back(mk(1, 4, 0, 2));
            prog.push_back(mk(3, 0, 1, 4)); prog.push_back(mk(0, 1, 1, 0));
            prog.push_back(mk(4, 0, 1, 0));
        end
        prog.push_back(mk(2, 0, 1, 0));
        run_prog();
        check("R10", issued_at[5] - issued_at[0], 10, "cycles per iteration");
        check("R10", issued_at[10] - issued_at[5], 10, "cycles second iteration");
        check("R10", last_stalls, 10, "bubbles over two iterations");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule